// File: doc/BRIEF.md
# Virtual Link Frame Filter and Policer

This block sits at the ingress of a rate-constrained avionics Ethernet switch and decides, for every arriving frame, whether it may be forwarded. The frame is presented once with a one-cycle start strobe, its destination MAC address, the number of the port it arrived on and its length. The low 16 bits of the destination MAC name the virtual link. That identifier selects an entry in a small, directly indexed configuration table. Each entry holds the permitted ingress port, a minimum and maximum frame length, a minimum spacing between frame starts, and a bitmap of egress ports.

Each frame receives one of two decisions. A frame that passes every check is forwarded to all ports set in its link's egress bitmap. A frame that fails a check is dropped, and a code names the first check that failed. The block keeps a per-link timestamp of the last accepted frame start and compares it with a free-running cycle counter. The table is loaded through a plain write port, one entry per cycle.

Top module: `vl_policer`

## Requirements
- R1: A frame is dropped with reason 1 (unknown link) in any of three cases: bits 47..16 of the destination MAC differ from the PREFIX parameter, the 16-bit identifier in bits 15..0 is not below DEPTH, or the selected entry was written with its valid bit clear.
- R2: A frame whose ingress port differs from the port configured for its link is dropped with reason 2.
- R3: A frame whose length is below the configured minimum or above the configured maximum is dropped with reason 3. Both limits are inclusive, so lengths equal to either limit pass.
- R4: A frame whose start comes fewer than BAG cycles after the start of the link's last accepted frame is dropped with reason 4. A spacing of exactly BAG cycles is accepted.
- R5: Checks are applied in the order R1, R2, R3, R4, and the reason code reports the first one that fails.
- R6: Only accepted frames move a link's last-start timestamp; a dropped frame leaves the spacing reference of its link unchanged.
- R7: The first frame on a link after its entry is written skips the spacing check.
- R8: Spacing uses modular subtraction on a TS_W-bit counter, so spacings shorter than 2^TS_W cycles are judged correctly across counter wraparound.
- R9: An accepted frame gives dec_fwd=1, dec_reason=0 and dec_egress equal to the link's bitmap. A dropped frame gives dec_fwd=0 and dec_egress=0.
- R10: Exactly one decision is produced per strobe. dec_valid is a one-cycle pulse two clock edges after the edge that samples sof. Outside that pulse, dec_fwd and dec_egress are 0.
- R11: After reset dec_valid is 0 and every table entry is invalid, so any frame is dropped with reason 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Frame start strobe, one cycle per frame |
| dst_mac | input | 48 | Destination MAC address of the frame |
| in_port | input | PORT_W | Ingress port number |
| frame_len | input | LEN_W | Frame length in bytes |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_valid | input | 1 | Entry enabled |
| cfg_port | input | PORT_W | Permitted ingress port |
| cfg_min_len | input | LEN_W | Minimum frame length |
| cfg_max_len | input | LEN_W | Maximum frame length |
| cfg_bag | input | TS_W | Minimum start-to-start spacing in cycles |
| cfg_egress | input | NUM_PORTS | Egress port bitmap |
| dec_valid | output | 1 | Decision strobe |
| dec_fwd | output | 1 | 1 = forward, 0 = drop |
| dec_egress | output | NUM_PORTS | Ports to forward to |
| dec_reason | output | 3 | 0 ok, 1 unknown link, 2 port, 3 length, 4 too early |

## Verification
The checker assumes sof stays low while reset is held. It also assumes sof is a single-cycle pulse tied to one frame, so that every decision pulse traces back to exactly one strobe. The bench drives sof only after reset is released, and only as a one-cycle pulse issued from its frame task on a falling edge. Spacing scenarios are built from counted idle cycles between strobes, so the bench knows each start-to-start distance exactly. Table writes are issued only while no frame is in flight, which keeps each decision tied to a single configuration.

// File: rtl/vl_pkg.sv
// Shared types for the virtual-link policer.
// Assumes: reason codes are 3 bits wide and ordered by check priority.
package vl_pkg;
    typedef enum logic [2:0] {
        RSN_OK      = 3'd0,
        RSN_UNKNOWN = 3'd1,
        RSN_PORT    = 3'd2,
        RSN_LEN     = 3'd3,
        RSN_EARLY   = 3'd4
    } reason_e;
endpackage

// File: rtl/vl_cfg_table.sv
// Per-link configuration and last-start storage, directly indexed.
// Assumes: a write and an accepted-frame update to the same entry in the
// same cycle resolve in favour of the write.
module vl_cfg_table #(
    parameter int DEPTH     = 16,
    parameter int PORT_W    = 3,
    parameter int LEN_W     = 11,
    parameter int TS_W      = 20,
    parameter int NUM_PORTS = 8,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_valid,
    input  logic [PORT_W-1:0]    wr_port,
    input  logic [LEN_W-1:0]     wr_min,
    input  logic [LEN_W-1:0]     wr_max,
    input  logic [TS_W-1:0]      wr_bag,
    input  logic [NUM_PORTS-1:0] wr_egress,
    input  logic                 upd_en,
    input  logic [IDX_W-1:0]     upd_idx,
    input  logic [TS_W-1:0]      upd_ts,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic                 rd_fresh,
    output logic [PORT_W-1:0]    rd_port,
    output logic [LEN_W-1:0]     rd_min,
    output logic [LEN_W-1:0]     rd_max,
    output logic [TS_W-1:0]      rd_bag,
    output logic [NUM_PORTS-1:0] rd_egress,
    output logic [TS_W-1:0]      rd_last
);
    logic                 valid_a  [DEPTH];
    logic                 fresh_a  [DEPTH];
    logic [PORT_W-1:0]    port_a   [DEPTH];
    logic [LEN_W-1:0]     min_a    [DEPTH];
    logic [LEN_W-1:0]     max_a    [DEPTH];
    logic [TS_W-1:0]      bag_a    [DEPTH];
    logic [NUM_PORTS-1:0] egress_a [DEPTH];
    logic [TS_W-1:0]      last_a   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic                 e_valid, e_fresh;
        logic [PORT_W-1:0]    e_port;
        logic [LEN_W-1:0]     e_min, e_max;
        logic [TS_W-1:0]      e_bag, e_last;
        logic [NUM_PORTS-1:0] e_egress;

        // Entry storage: load on write, refresh timestamp on acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid  <= 1'b0;
                e_fresh  <= 1'b1;
                e_port   <= '0;
                e_min    <= '0;
                e_max    <= '0;
                e_bag    <= '0;
                e_egress <= '0;
                e_last   <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                e_valid  <= wr_valid;
                e_fresh  <= 1'b1;
                e_port   <= wr_port;
                e_min    <= wr_min;
                e_max    <= wr_max;
                e_bag    <= wr_bag;
                e_egress <= wr_egress;
            end else if (upd_en && (upd_idx == IDX_W'(i))) begin
                e_last  <= upd_ts;
                e_fresh <= 1'b0;
            end
        end

        assign valid_a[i]  = e_valid;
        assign fresh_a[i]  = e_fresh;
        assign port_a[i]   = e_port;
        assign min_a[i]    = e_min;
        assign max_a[i]    = e_max;
        assign bag_a[i]    = e_bag;
        assign egress_a[i] = e_egress;
        assign last_a[i]   = e_last;
    end

    // Read port: select the addressed entry.
    always_comb begin
        rd_valid  = valid_a[rd_idx];
        rd_fresh  = fresh_a[rd_idx];
        rd_port   = port_a[rd_idx];
        rd_min    = min_a[rd_idx];
        rd_max    = max_a[rd_idx];
        rd_bag    = bag_a[rd_idx];
        rd_egress = egress_a[rd_idx];
        rd_last   = last_a[rd_idx];
    end
endmodule

// File: rtl/vl_rule_check.sv
// Ordered frame checks: link known, ingress port, length window, spacing.
// Assumes: the entry fields belong to the frame's link; spacing is taken
// modulo 2^TS_W, so true spacings must stay below that span.
module vl_rule_check #(
    parameter int PORT_W = 3,
    parameter int LEN_W  = 11,
    parameter int TS_W   = 20
) (
    input  logic              known,
    input  logic [PORT_W-1:0] frm_port,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [TS_W-1:0]   frm_ts,
    input  logic              ent_fresh,
    input  logic [PORT_W-1:0] ent_port,
    input  logic [LEN_W-1:0]  ent_min,
    input  logic [LEN_W-1:0]  ent_max,
    input  logic [TS_W-1:0]   ent_bag,
    input  logic [TS_W-1:0]   ent_last,
    output vl_pkg::reason_e   reason
);
    logic [TS_W-1:0] elapsed;

    // Modular distance from the last accepted start.
    always_comb elapsed = frm_ts - ent_last;

    // First failing check wins.
    always_comb begin
        if (!known)
            reason = vl_pkg::RSN_UNKNOWN;
        else if (frm_port != ent_port)
            reason = vl_pkg::RSN_PORT;
        else if ((frm_len < ent_min) || (frm_len > ent_max))
            reason = vl_pkg::RSN_LEN;
        else if (!ent_fresh && (elapsed < ent_bag))
            reason = vl_pkg::RSN_EARLY;
        else
            reason = vl_pkg::RSN_OK;
    end
endmodule

// File: rtl/vl_policer.sv
// Virtual-link ingress filter and policer. Stage 1 registers the frame and
// its start time; stage 2 checks it against the live table entry, records
// accepted starts and registers the decision (two edges after sof).
// Assumes: sof is a single-cycle strobe, low during reset.
module vl_policer #(
    parameter logic [31:0] PREFIX    = 32'h0300_0000,
    parameter int          DEPTH     = 16,
    parameter int          NUM_PORTS = 8,
    parameter int          LEN_W     = 11,
    parameter int          TS_W      = 20,
    localparam int         PORT_W    = $clog2(NUM_PORTS),
    localparam int         IDX_W     = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sof,
    input  logic [47:0]          dst_mac,
    input  logic [PORT_W-1:0]    in_port,
    input  logic [LEN_W-1:0]     frame_len,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_valid,
    input  logic [PORT_W-1:0]    cfg_port,
    input  logic [LEN_W-1:0]     cfg_min_len,
    input  logic [LEN_W-1:0]     cfg_max_len,
    input  logic [TS_W-1:0]      cfg_bag,
    input  logic [NUM_PORTS-1:0] cfg_egress,
    output logic                 dec_valid,
    output logic                 dec_fwd,
    output logic [NUM_PORTS-1:0] dec_egress,
    output logic [2:0]           dec_reason
);
    logic [TS_W-1:0]      ts_now;
    logic                 s1_vld, s1_prefix_ok;
    logic [15:0]          s1_vlid;
    logic [PORT_W-1:0]    s1_port;
    logic [LEN_W-1:0]     s1_len;
    logic [TS_W-1:0]      s1_ts;
    logic [IDX_W-1:0]     s1_idx;
    logic                 s1_in_range, s1_known;
    logic                 e_valid, e_fresh;
    logic [PORT_W-1:0]    e_port;
    logic [LEN_W-1:0]     e_min, e_max;
    logic [TS_W-1:0]      e_bag, e_last;
    logic [NUM_PORTS-1:0] e_egress;
    vl_pkg::reason_e      verdict;
    logic                 accept;

    // Free-running time base for start spacing.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_now <= '0;
        else        ts_now <= ts_now + 1'b1;
    end

    // Stage 1: capture frame fields and start time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld       <= 1'b0;
            s1_prefix_ok <= 1'b0;
            s1_vlid      <= '0;
            s1_port      <= '0;
            s1_len       <= '0;
            s1_ts        <= '0;
        end else begin
            s1_vld       <= sof;
            s1_prefix_ok <= (dst_mac[47:16] == PREFIX);
            s1_vlid      <= dst_mac[15:0];
            s1_port      <= in_port;
            s1_len       <= frame_len;
            s1_ts        <= ts_now;
        end
    end

    // Link lookup: identifier must address an existing, enabled entry.
    always_comb begin
        s1_idx      = s1_vlid[IDX_W-1:0];
        s1_in_range = ({16'd0, s1_vlid} >> IDX_W) == 32'd0;
        s1_known    = s1_prefix_ok && s1_in_range && e_valid;
    end

    vl_cfg_table #(
        .DEPTH(DEPTH), .PORT_W(PORT_W), .LEN_W(LEN_W),
        .TS_W(TS_W), .NUM_PORTS(NUM_PORTS)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid),
        .wr_port(cfg_port), .wr_min(cfg_min_len), .wr_max(cfg_max_len),
        .wr_bag(cfg_bag), .wr_egress(cfg_egress),
        .upd_en(accept), .upd_idx(s1_idx), .upd_ts(s1_ts),
        .rd_idx(s1_idx),
        .rd_valid(e_valid), .rd_fresh(e_fresh), .rd_port(e_port),
        .rd_min(e_min), .rd_max(e_max), .rd_bag(e_bag),
        .rd_egress(e_egress), .rd_last(e_last)
    );

    vl_rule_check #(.PORT_W(PORT_W), .LEN_W(LEN_W), .TS_W(TS_W)) u_check (
        .known(s1_known), .frm_port(s1_port), .frm_len(s1_len),
        .frm_ts(s1_ts), .ent_fresh(e_fresh), .ent_port(e_port),
        .ent_min(e_min), .ent_max(e_max), .ent_bag(e_bag),
        .ent_last(e_last), .reason(verdict)
    );

    // Timestamp update only for frames that pass every check.
    always_comb accept = s1_vld && (verdict == vl_pkg::RSN_OK);

    // Stage 2: register the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_fwd    <= 1'b0;
            dec_egress <= '0;
            dec_reason <= '0;
        end else begin
            dec_valid  <= s1_vld;
            dec_fwd    <= accept;
            dec_egress <= accept ? e_egress : '0;
            dec_reason <= s1_vld ? verdict : vl_pkg::RSN_OK;
        end
    end
endmodule

// File: rtl/vl_policer_chk.sv
// Port-level properties of the policer, bound to every instance.
// Assumes: sof is low while rst_n is low.
module vl_policer_chk #(
    parameter logic [31:0] PREFIX    = 32'h0300_0000,
    parameter int          NUM_PORTS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sof,
    input logic [31:0]          mac_hi,
    input logic                 dec_valid,
    input logic                 dec_fwd,
    input logic [NUM_PORTS-1:0] dec_egress,
    input logic [2:0]           dec_reason
);
    // R10: one decision pulse two edges after each strobe
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == $past(sof, 2));

    // R10: no forwarding outside a decision pulse
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_fwd && dec_egress == '0));

    // R9: dropped frames go nowhere
    a_r9_drop_no_egress: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_fwd) |-> (dec_egress == '0));

    // R9: forward exactly when the reason is zero
    a_r9_fwd_reason: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_fwd == (dec_reason == 3'd0)));

    // R5: reason code stays within the defined set
    a_r5_reason_range: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_reason <= 3'd4));

    // R1: a foreign address prefix always ends as unknown link
    a_r1_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && mac_hi != PREFIX) |-> ##2 (dec_valid && dec_reason == 3'd1));
endmodule

bind vl_policer vl_policer_chk #(.PREFIX(PREFIX), .NUM_PORTS(NUM_PORTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sof(sof), .mac_hi(dst_mac[47:16]),
    .dec_valid(dec_valid), .dec_fwd(dec_fwd),
    .dec_egress(dec_egress), .dec_reason(dec_reason)
);

// File: tb/tb_vl_policer.sv
module tb_vl_policer;
    localparam logic [31:0] PFX = 32'h0300_0000;
    localparam int NP = 8, LW = 11, TW = 10, DP = 16;

    logic clk = 1'b0, rst_n = 1'b0, sof = 1'b0;
    logic [47:0] dst_mac = '0;
    logic [2:0] in_port = '0;
    logic [LW-1:0] frame_len = '0;
    logic cfg_we = 1'b0, cfg_valid = 1'b0;
    logic [3:0] cfg_idx = '0;
    logic [2:0] cfg_port = '0;
    logic [LW-1:0] cfg_min_len = '0, cfg_max_len = '0;
    logic [TW-1:0] cfg_bag = '0;
    logic [NP-1:0] cfg_egress = '0;
    logic dec_valid, dec_fwd;
    logic [NP-1:0] dec_egress;
    logic [2:0] dec_reason;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vl_policer #(.PREFIX(PFX), .DEPTH(DP), .NUM_PORTS(NP), .LEN_W(LW), .TS_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .sof(sof), .dst_mac(dst_mac),
        .in_port(in_port), .frame_len(frame_len), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_port(cfg_port),
        .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
        .cfg_bag(cfg_bag), .cfg_egress(cfg_egress),
        .dec_valid(dec_valid), .dec_fwd(dec_fwd),
        .dec_egress(dec_egress), .dec_reason(dec_reason)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(int idx, bit vld, int port, int mn, int mx, int bag, int eg);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_valid = vld; cfg_port = 3'(port);
        cfg_min_len = LW'(mn); cfg_max_len = LW'(mx); cfg_bag = TW'(bag);
        cfg_egress = NP'(eg);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one frame and check its decision two edges later.
    task automatic send(string req, logic [47:0] mac, int port, int len,
                        bit exp_fwd, int exp_rsn, int exp_eg);
        dst_mac = mac; in_port = 3'(port); frame_len = LW'(len); sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        check({req, " R10 early"}, 32'(dec_valid), 32'd0);
        @(negedge clk);
        check({req, " R10 valid"}, 32'(dec_valid), 32'd1);
        check({req, " fwd"}, 32'(dec_fwd), 32'(exp_fwd));
        check({req, " reason"}, 32'(dec_reason), 32'(exp_rsn));
        check({req, " R9 egress"}, 32'(dec_egress), 32'(exp_eg));
    endtask

    function automatic logic [47:0] mac_of(int vl);
        return {PFX, 16'(vl)};
    endfunction

    task automatic t_reset();
        check("R11 dec_valid in reset", 32'(dec_valid), 32'd0);
        send("R11 empty table", mac_of(3), 2, 100, 1'b0, 1, 0);
    endtask

    task automatic t_forward();
        cfg_write(3, 1, 2, 64, 1518, 0, 8'h06);
        send("R9 multicast", mac_of(3), 2, 500, 1'b1, 0, 8'h06);
    endtask

    task automatic t_unknown();
        cfg_write(7, 0, 0, 64, 1518, 0, 8'hFF);
        send("R1 beyond depth", mac_of(20), 2, 500, 1'b0, 1, 0);
        send("R1 prefix", {32'h0300_0001, 16'd3}, 2, 500, 1'b0, 1, 0);
        send("R1 disabled", mac_of(7), 0, 500, 1'b0, 1, 0);
    endtask

    task automatic t_port();
        send("R2 wrong port", mac_of(3), 4, 500, 1'b0, 2, 0);
    endtask

    task automatic t_length();
        cfg_write(5, 1, 1, 100, 200, 0, 8'h81);
        send("R3 below min", mac_of(5), 1, 99, 1'b0, 3, 0);
        send("R3 at min", mac_of(5), 1, 100, 1'b1, 0, 8'h81);
        send("R3 at max", mac_of(5), 1, 200, 1'b1, 0, 8'h81);
        send("R3 above max", mac_of(5), 1, 201, 1'b0, 3, 0);
    endtask

    task automatic t_priority();
        send("R5 port before length", mac_of(5), 0, 50, 1'b0, 2, 0);
        cfg_write(9, 1, 1, 64, 100, 50, 8'h02);
        send("R5 first ok", mac_of(9), 1, 70, 1'b1, 0, 8'h02);
        send("R5 length before timing", mac_of(9), 1, 200, 1'b0, 3, 0);
        send("R5 timing last", mac_of(9), 1, 70, 1'b0, 4, 0);
    endtask

    task automatic t_gap();
        cfg_write(10, 1, 0, 64, 1500, 10, 8'h10);
        send("R7 fresh accept", mac_of(10), 0, 64, 1'b1, 0, 8'h10);
        idle(6);
        send("R4 spacing 8", mac_of(10), 0, 64, 1'b0, 4, 0);
        send("R6 spacing 10 from accepted", mac_of(10), 0, 64, 1'b1, 0, 8'h10);
        idle(7);
        send("R4 spacing 9", mac_of(10), 0, 64, 1'b0, 4, 0);
        cfg_write(10, 1, 0, 64, 1500, 10, 8'h10);
        send("R7 rewrite skips gap", mac_of(10), 0, 64, 1'b1, 0, 8'h10);
        send("R4 after rewrite", mac_of(10), 0, 64, 1'b0, 4, 0);
    endtask

    task automatic t_wrap();
        cfg_write(11, 1, 3, 64, 1500, 290, 8'h40);
        send("R8 start", mac_of(11), 3, 64, 1'b1, 0, 8'h40);
        for (int k = 0; k < 8; k++) begin
            idle(198);
            send("R8 spacing 200", mac_of(11), 3, 64, 1'b0, 4, 0);
            idle(98);
            send("R8 spacing 300", mac_of(11), 3, 64, 1'b1, 0, 8'h40);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset_pre: begin
            check("R11 dec_fwd in reset", 32'(dec_fwd), 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_unknown();
        t_port();
        t_length();
        t_priority();
        t_gap();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule